// File: doc/BRIEF.md
# Rename Serialize-Stall Controller

This block is the control path of a single-thread out-of-order rename stage. Instructions arrive from decode over a valid/ready handshake. Each one carries an opaque tag and two flags: serialize-before and temporary-serialize. Renamed instructions leave toward dispatch as a valid-qualified push. Dispatch has no ready signal. Back-pressure from the back end arrives instead on plain status pins: a block request, ROB/IQ/LSQ full flags and a signed free rename-register count. Those pins move the stage into a blocked state. While blocked, the stage parks incoming work in a small skid buffer.

An instruction that must serialize is caught in a holding register and is not sent on. The stage then waits until the ROB is empty and no instruction is in flight toward it. Block requests and full flags cannot pull the stage out of this wait. Once the ROB has drained, the held instruction, with its serialize flag cleared, goes back in at the head of the skid buffer. It therefore leaves ahead of every older parked entry. A squash discards both the buffer and the held instruction.

The stage keeps twelve event counters. Six count cycles, one for each state. Four count stall causes. Two count serializing instructions.

Handshake rules: an input beat is taken when `in_valid` and `in_ready` are both high at a rising clock edge. Decode must hold the beat stable until it is taken. `in_ready` depends only on the state, the stall inputs and the skid occupancy, never on `in_valid`. `out_valid` and `out_tag` are combinational and are valid in the same cycle the instruction is taken or popped.

Top module: `rn_serial_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the stage in Idle with the skid buffer empty, no instruction held and all counters at zero. Status codes are Running=0, Idle=1, Blocked=2, Unblocking=3, Squashing=4 and SerializeStall=5.
- R2: In Running or Idle with no stall and no squash, `in_ready` is high. A taken instruction that is not serializing appears on `out_valid`/`out_tag` in the same cycle. The next state is Running if a beat was taken and Idle otherwise.
- R3: A taken instruction with serialize-before set and not yet marked handled produces no output. It is held, and the state becomes SerializeStall on the next cycle. If it is non-temporary it is marked handled and counter 10 increments. If it is temporary, counter 11 increments instead.
- R4: In SerializeStall, `in_ready` is low. Neither a block request nor any full flag or empty free-register count changes the state.
- R5: SerializeStall persists while the ROB is not empty or the in-flight count is nonzero. In the first cycle in which both conditions clear, the held instruction is reinserted at the head of the skid buffer with serialize-before cleared, and the next state is Unblocking. It leaves before any entry that was already buffered.
- R6: A stall is any of: block request, ROB full, IQ full, LSQ full, or a free-register count of zero or below. A stall in Running or Idle drops `in_ready`, pulses `dec_block` for one cycle and moves to Blocked.
- R7: In Blocked, beats are taken into the skid buffer while it holds fewer than SKID_DEPTH entries, with no output. When the stall clears, the next state is Unblocking.
- R8: In Unblocking without stall, `in_ready` is low and one buffered entry is popped and processed per cycle, in FIFO order. When the buffer is empty, `dec_unblock` pulses and the next state is Running. A stall in Unblocking pulses `dec_block`, moves to Blocked and takes beats into the buffer.
- R9: A squash sets the next state to Squashing and empties the skid buffer and the holding register. `in_ready` is low and nothing is output. `dec_unblock` is high in that cycle exactly when the state is Blocked, Unblocking or SerializeStall.
- R10: In Squashing, nothing is taken. The first cycle with squash low moves the stage to Running.
- R11: Counter i occupies `counters[i*CNT_W +: CNT_W]`. Counters 0 to 5 are cycle counters indexed by status code, and exactly one of them increments each cycle.
- R12: In Running, Idle, Blocked or Unblocking, in a cycle without squash, at most one stall-event counter increments. The priority is ROB full (counter 6), then IQ full (7), then LSQ full (8), then free registers at or below zero (9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decode offers an instruction |
| in_ready | output | 1 | Stage takes the offered instruction this cycle |
| in_tag | input | TAG_W | Opaque instruction tag |
| in_ser_before | input | 1 | Instruction must serialize before renaming |
| in_ser_temp | input | 1 | Serialization is temporary (not marked handled) |
| out_valid | output | 1 | Renamed instruction sent to dispatch |
| out_tag | output | TAG_W | Tag of the renamed instruction |
| blk_req | input | 1 | Block request from later stages |
| rob_empty | input | 1 | ROB holds no instructions |
| rob_full | input | 1 | ROB full |
| iq_full | input | 1 | Issue queue full |
| lsq_full | input | 1 | Load/store queue full |
| free_regs | input | FREE_W (signed) | Free rename-register count |
| inflight | input | INF_W | Instructions in flight toward the ROB |
| squash | input | 1 | Squash request |
| dec_block | output | 1 | One-cycle block pulse to decode |
| dec_unblock | output | 1 | Unblock pulse to decode |
| status | output | 3 | Current state code |
| counters | output | 12*CNT_W | Packed event and cycle counters |

## Verification
A wrong state in this block shows at the ports at once. `status` carries the state code on every cycle. A corrupted state, a lost held instruction or a bad skid pointer also changes `in_ready`, `out_valid` or `out_tag` in the very next cycle in which that state is used. For example, a forgotten serialize wait shows as an early `in_ready` or a missing reinserted tag. A misordered reinsertion shows as the wrong tag in the first Unblocking pop. The packed counters reveal a miscounted state or a wrong stall priority in the cycle right after the event. For these reasons, the reference model is compared against every output on every cycle.

// File: rtl/rn_serial_pkg.sv
package rn_serial_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_BLOCK  = 3'd2,
    ST_UNBLK  = 3'd3,
    ST_SQUASH = 3'd4,
    ST_SSTALL = 3'd5
  } rn_state_e;

  localparam int NUM_STATES = 6;

  // counter indexes following the per-state cycle counters
  localparam int EV_ROB   = 6;
  localparam int EV_IQ    = 7;
  localparam int EV_LSQ   = 8;
  localparam int EV_NOREG = 9;
  localparam int EV_SER   = 10;
  localparam int EV_TSER  = 11;
  localparam int NUM_CTRS = 12;

  // entry layout: {tag, ser_before, ser_temp, handled}
  localparam int FLD_DONE = 0;
  localparam int FLD_TMP  = 1;
  localparam int FLD_SB   = 2;
  localparam int FLD_TAG  = 3;

endpackage

// File: rtl/rn_skid_fifo.sv
module rn_skid_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push_back,
  input  logic         push_front,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (push_front) begin
      rd_ptr <= ptr_dec(rd_ptr);
      cnt    <= cnt + 1'b1;
    end else if (pop) begin
      rd_ptr <= ptr_inc(rd_ptr);
      cnt    <= cnt - 1'b1;
    end else if (push_back) begin
      wr_ptr <= ptr_inc(wr_ptr);
      cnt    <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && !flush) begin
      if (push_front)
        mem[ptr_dec(rd_ptr)] <= din;
      else if (!pop && push_back)
        mem[wr_ptr] <= din;
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    !(full && !flush && (push_back || push_front)));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    !(empty && !flush && pop));

  assert_single_op_R8: assert property (@(posedge clk) disable iff (rst)
    $countones({push_back, push_front, pop}) <= 1);

endmodule

// File: rtl/rn_ser_hold.sv
module rn_ser_hold
  import rn_serial_pkg::*;
#(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic         drop,
  input  logic [W-1:0] din,
  output logic         valid,
  output logic [W-1:0] rel_ent
);

  localparam logic [W-1:0] DONE_MASK = W'(1) << FLD_DONE;
  localparam logic [W-1:0] SB_MASK   = W'(1) << FLD_SB;

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (drop) begin
      valid <= 1'b0;
    end else if (capture) begin
      valid <= 1'b1;
      // only a non-temporary serializer is marked handled
      q     <= din[FLD_TMP] ? din : (din | DONE_MASK);
    end
  end

  // reinsertion copy: serialize-before removed
  assign rel_ent = q & ~SB_MASK;

  assert_capture_free_R3: assert property (@(posedge clk) disable iff (rst)
    capture |-> !valid);

endmodule

// File: rtl/rn_ctr_bank.sv
module rn_ctr_bank #(
  parameter int N = 12,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   inc,
  output logic [N*W-1:0] cnt_bus
);

  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic [W-1:0] val;
    always_ff @(posedge clk) begin
      if (rst)
        val <= '0;
      else if (inc[g])
        val <= val + 1'b1;
    end
    assign cnt_bus[g*W +: W] = val;
  end

endmodule

// File: rtl/rn_serial_ctrl.sv
module rn_serial_ctrl
  import rn_serial_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter int SKID_DEPTH = 4,
  parameter int CNT_W      = 16,
  parameter int FREE_W     = 6,
  parameter int INF_W      = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [TAG_W-1:0]          in_tag,
  input  logic                      in_ser_before,
  input  logic                      in_ser_temp,
  output logic                      out_valid,
  output logic [TAG_W-1:0]          out_tag,
  input  logic                      blk_req,
  input  logic                      rob_empty,
  input  logic                      rob_full,
  input  logic                      iq_full,
  input  logic                      lsq_full,
  input  logic signed [FREE_W-1:0]  free_regs,
  input  logic [INF_W-1:0]          inflight,
  input  logic                      squash,
  output logic                      dec_block,
  output logic                      dec_unblock,
  output logic [2:0]                status,
  output logic [NUM_CTRS*CNT_W-1:0] counters
);

  localparam int ENT_W = TAG_W + FLD_TAG;

  rn_state_e st;
  rn_state_e nxt;

  logic [ENT_W-1:0] in_ent;
  logic [ENT_W-1:0] skid_head;
  logic [ENT_W-1:0] skid_din;
  logic [ENT_W-1:0] hold_rel;
  logic [ENT_W-1:0] cand;
  logic             cand_v;
  logic             skid_empty;
  logic             skid_full;
  logic             skid_pushb;
  logic             skid_pushf;
  logic             skid_pop;
  logic             skid_flush;
  logic             hold_v;
  logic             hold_cap;
  logic             hold_drop;
  logic             noreg;
  logic             rstall;
  logic             stall;
  logic             drained;
  logic [NUM_CTRS-1:0] ctr_inc;

  assign in_ent  = {in_tag, in_ser_before, in_ser_temp, 1'b0};
  assign noreg   = free_regs[FREE_W-1] || (free_regs == '0);
  assign rstall  = rob_full || iq_full || lsq_full || noreg;
  assign stall   = rstall || blk_req;
  assign drained = rob_empty && (inflight == '0);

  assign skid_din = skid_pushf ? hold_rel : in_ent;

  // next-state and datapath steering
  always_comb begin
    nxt         = st;
    in_ready    = 1'b0;
    skid_pushb  = 1'b0;
    skid_pushf  = 1'b0;
    skid_pop    = 1'b0;
    skid_flush  = 1'b0;
    hold_drop   = 1'b0;
    hold_cap    = 1'b0;
    cand_v      = 1'b0;
    cand        = in_ent;
    out_valid   = 1'b0;
    dec_block   = 1'b0;
    dec_unblock = 1'b0;

    if (squash) begin
      nxt         = ST_SQUASH;
      skid_flush  = 1'b1;
      hold_drop   = 1'b1;
      dec_unblock = (st == ST_BLOCK) || (st == ST_UNBLK) || (st == ST_SSTALL);
    end else begin
      unique case (st)
        ST_SQUASH: nxt = ST_RUN;
        ST_RUN, ST_IDLE: begin
          if (stall) begin
            nxt       = ST_BLOCK;
            dec_block = 1'b1;
          end else begin
            in_ready = 1'b1;
            cand_v   = in_valid;
            nxt      = in_valid ? ST_RUN : ST_IDLE;
          end
        end
        ST_BLOCK: begin
          in_ready   = !skid_full;
          skid_pushb = in_valid && !skid_full;
          if (!stall) nxt = ST_UNBLK;
        end
        ST_UNBLK: begin
          if (stall) begin
            nxt        = ST_BLOCK;
            dec_block  = 1'b1;
            in_ready   = !skid_full;
            skid_pushb = in_valid && !skid_full;
          end else if (skid_empty) begin
            nxt         = ST_RUN;
            dec_unblock = 1'b1;
          end else begin
            skid_pop = 1'b1;
            cand     = skid_head;
            cand_v   = 1'b1;
          end
        end
        ST_SSTALL: begin
          if (drained) begin
            nxt        = ST_UNBLK;
            skid_pushf = 1'b1;
            hold_drop  = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase

      if (cand_v) begin
        if (cand[FLD_SB] && !cand[FLD_DONE]) begin
          hold_cap = 1'b1;
          nxt      = ST_SSTALL;
        end else begin
          out_valid = 1'b1;
        end
      end
    end
  end

  assign out_tag = cand[ENT_W-1:FLD_TAG];
  assign status  = st;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  // counter increments
  always_comb begin
    ctr_inc = '0;
    for (int i = 0; i < NUM_STATES; i++)
      if (int'(st) == i) ctr_inc[i] = 1'b1;
    if (!squash && (st == ST_RUN || st == ST_IDLE || st == ST_BLOCK || st == ST_UNBLK)) begin
      if (rob_full)      ctr_inc[EV_ROB]   = 1'b1;
      else if (iq_full)  ctr_inc[EV_IQ]    = 1'b1;
      else if (lsq_full) ctr_inc[EV_LSQ]   = 1'b1;
      else if (noreg)    ctr_inc[EV_NOREG] = 1'b1;
    end
    if (hold_cap) begin
      if (cand[FLD_TMP]) ctr_inc[EV_TSER] = 1'b1;
      else               ctr_inc[EV_SER]  = 1'b1;
    end
  end

  rn_skid_fifo #(
    .DEPTH (SKID_DEPTH),
    .W     (ENT_W)
  ) u_skid (
    .clk        (clk),
    .rst        (rst),
    .flush      (skid_flush),
    .push_back  (skid_pushb),
    .push_front (skid_pushf),
    .pop        (skid_pop),
    .din        (skid_din),
    .head       (skid_head),
    .empty      (skid_empty),
    .full       (skid_full)
  );

  rn_ser_hold #(
    .W (ENT_W)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (hold_cap),
    .drop    (hold_drop),
    .din     (cand),
    .valid   (hold_v),
    .rel_ent (hold_rel)
  );

  rn_ctr_bank #(
    .N (NUM_CTRS),
    .W (CNT_W)
  ) u_ctrs (
    .clk     (clk),
    .rst     (rst),
    .inc     (ctr_inc),
    .cnt_bus (counters)
  );

  assert_hold_in_sstall_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SSTALL) |-> hold_v);

  assert_sstall_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SSTALL && !squash && !(rob_empty && inflight == '0)) |=> (st == ST_SSTALL));

  assert_drain_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SSTALL && !squash && rob_empty && inflight == '0) |=> (st == ST_UNBLK && !skid_empty));

  assert_squash_clears_R9: assert property (@(posedge clk) disable iff (rst)
    squash |=> (st == ST_SQUASH && skid_empty && !hold_v));

  assert_no_take_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SQUASH || st == ST_SSTALL) |-> !in_ready);

  assert_out_source_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (st == ST_RUN || st == ST_IDLE || st == ST_UNBLK));

endmodule

// File: tb/rn_serial_ctrl_bench.sv
module rn_serial_ctrl_bench;

  localparam int TAG_W = 8;
  localparam int CNT_W = 16;
  localparam int NC    = 12;
  localparam int S_RUN = 0, S_IDLE = 1, S_BLK = 2, S_UNB = 3, S_SQ = 4, S_SS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             in_valid = 0;
  logic [TAG_W-1:0] in_tag = 0;
  logic             in_sb = 0, in_tmp = 0;
  logic             blk = 0, rob_empty = 1, rob_full = 0, iq_full = 0, lsq_full = 0, squash = 0;
  logic signed [5:0] free_regs = 6'sd8;
  logic [3:0]       inflight = 0;

  logic             in_ready, out_valid, dec_block, dec_unblock;
  logic [TAG_W-1:0] out_tag;
  logic [2:0]       status;
  logic [NC*CNT_W-1:0] counters;

  rn_serial_ctrl u_rn_serial_ctrl (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
    .in_ser_before(in_sb), .in_ser_temp(in_tmp),
    .out_valid(out_valid), .out_tag(out_tag),
    .blk_req(blk), .rob_empty(rob_empty), .rob_full(rob_full),
    .iq_full(iq_full), .lsq_full(lsq_full), .free_regs(free_regs),
    .inflight(inflight), .squash(squash),
    .dec_block(dec_block), .dec_unblock(dec_unblock),
    .status(status), .counters(counters)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  // behavioural reference model
  int m_st;
  int q_tag[$];
  bit q_sb[$], q_tmp[$], q_done[$];
  bit h_v, h_tmp;
  int h_tag;
  int m_cnt[NC];

  bit e_rdy, e_ov, e_blk, e_unb, acc;
  int e_tag, n_st;
  bit a_flush, a_pf, a_pop, a_pb, a_cap;
  int c_tag;
  bit c_sb, c_tmp, c_done, c_v;

  function automatic void model_eval();
    bit stall;
    stall = blk || rob_full || iq_full || lsq_full || (free_regs <= 0);
    e_rdy = 0; e_ov = 0; e_blk = 0; e_unb = 0; e_tag = 0;
    a_flush = 0; a_pf = 0; a_pop = 0; a_pb = 0; a_cap = 0; c_v = 0;
    n_st = m_st;
    if (squash) begin
      n_st = S_SQ; a_flush = 1;
      e_unb = (m_st == S_BLK || m_st == S_UNB || m_st == S_SS);
    end else begin
      case (m_st)
        S_SQ: n_st = S_RUN;
        S_RUN, S_IDLE: begin
          if (stall) begin n_st = S_BLK; e_blk = 1; end
          else begin
            e_rdy = 1;
            n_st = in_valid ? S_RUN : S_IDLE;
            if (in_valid) begin c_v = 1; c_tag = in_tag; c_sb = in_sb; c_tmp = in_tmp; c_done = 0; end
          end
        end
        S_BLK: begin
          e_rdy = (q_tag.size() < 4);
          a_pb = in_valid && e_rdy;
          if (!stall) n_st = S_UNB;
        end
        S_UNB: begin
          if (stall) begin
            n_st = S_BLK; e_blk = 1;
            e_rdy = (q_tag.size() < 4);
            a_pb = in_valid && e_rdy;
          end else if (q_tag.size() == 0) begin
            n_st = S_RUN; e_unb = 1;
          end else begin
            a_pop = 1; c_v = 1;
            c_tag = q_tag[0]; c_sb = q_sb[0]; c_tmp = q_tmp[0]; c_done = q_done[0];
          end
        end
        S_SS: if (rob_empty && inflight == 0) begin n_st = S_UNB; a_pf = 1; end
        default: ;
      endcase
      if (c_v) begin
        if (c_sb && !c_done) begin a_cap = 1; n_st = S_SS; end
        else begin e_ov = 1; e_tag = c_tag; end
      end
    end
  endfunction

  task automatic model_apply();
    if (a_flush) begin
      q_tag.delete(); q_sb.delete(); q_tmp.delete(); q_done.delete();
    end else if (a_pf) begin
      q_tag.push_front(h_tag); q_sb.push_front(0); q_tmp.push_front(h_tmp); q_done.push_front(!h_tmp);
    end else if (a_pop) begin
      void'(q_tag.pop_front()); void'(q_sb.pop_front()); void'(q_tmp.pop_front()); void'(q_done.pop_front());
    end else if (a_pb) begin
      q_tag.push_back(in_tag); q_sb.push_back(in_sb); q_tmp.push_back(in_tmp); q_done.push_back(0);
    end
    if (a_flush || a_pf) h_v = 0;
    if (a_cap) begin h_v = 1; h_tag = c_tag; h_tmp = c_tmp; end
    m_cnt[m_st]++;
    if (!squash && m_st <= S_UNB) begin
      if (rob_full) m_cnt[6]++;
      else if (iq_full) m_cnt[7]++;
      else if (lsq_full) m_cnt[8]++;
      else if (free_regs <= 0) m_cnt[9]++;
    end
    if (a_cap) m_cnt[c_tmp ? 11 : 10]++;
    m_st = n_st;
  endtask

  task automatic tick();
    #1;
    model_eval();
    chk(int'(status) == m_st, cur_req, "status", int'(status), m_st);
    chk(in_ready === e_rdy, cur_req, "in_ready", int'(in_ready), int'(e_rdy));
    chk(out_valid === e_ov, cur_req, "out_valid", int'(out_valid), int'(e_ov));
    if (e_ov) chk(int'(out_tag) == e_tag, cur_req, "out_tag", int'(out_tag), e_tag);
    chk(dec_block === e_blk, cur_req, "dec_block", int'(dec_block), int'(e_blk));
    chk(dec_unblock === e_unb, cur_req, "dec_unblock", int'(dec_unblock), int'(e_unb));
    for (int k = 0; k < NC; k++)
      chk(int'(counters[k*CNT_W +: CNT_W]) == m_cnt[k], (k < 6) ? "R11" : (k < 10) ? "R12" : "R3",
          $sformatf("counter%0d", k), int'(counters[k*CNT_W +: CNT_W]), m_cnt[k]);
    acc = in_valid && e_rdy;
    @(posedge clk);
    model_apply();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic stream(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      if (acc) in_tag = in_tag + 1'b1;
    end
  endtask

  task automatic send(int tag, bit sb, bit tmp);
    in_valid = 1; in_tag = TAG_W'(tag); in_sb = sb; in_tmp = tmp;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (acc) break;
    end
    in_valid = 0; in_sb = 0; in_tmp = 0;
  endtask

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_st = S_IDLE; h_v = 0;
    for (int k = 0; k < NC; k++) m_cnt[k] = 0;

    cur_req = "R1";
    idle(2);

    cur_req = "R2";
    send(8'h11, 0, 0); send(8'h12, 0, 0); send(8'h13, 0, 0);
    idle(2);

    cur_req = "R6";
    rob_full = 1; in_valid = 1; in_tag = 8'h21;
    stream(1);
    cur_req = "R7";
    stream(6);
    cur_req = "R8";
    rob_full = 0;
    stream(8);
    blk = 1; stream(2);
    blk = 0; stream(1);
    blk = 1; stream(2);
    blk = 0; in_valid = 0;
    idle(8);

    cur_req = "R12";
    iq_full = 1; idle(2); iq_full = 0;
    lsq_full = 1; idle(2); lsq_full = 0;
    free_regs = 0; idle(2);
    free_regs = -3; idle(2); free_regs = 8;
    rob_full = 1; iq_full = 1; lsq_full = 1; idle(2);
    rob_full = 0; iq_full = 0; lsq_full = 0;
    idle(6);

    cur_req = "R3";
    rob_empty = 0; inflight = 2;
    send(8'h40, 1, 0);
    in_valid = 1; in_tag = 8'h41;
    cur_req = "R4";
    blk = 1; iq_full = 1; free_regs = 0;
    stream(3);
    blk = 0; iq_full = 0; free_regs = 8;
    cur_req = "R5";
    rob_empty = 1; stream(2);
    inflight = 0; stream(6);
    in_valid = 0; idle(2);

    cur_req = "R3";
    rob_empty = 0;
    send(8'h50, 1, 1);
    idle(2);
    rob_empty = 1;
    idle(4);

    cur_req = "R5";
    blk = 1;
    send(8'h60, 0, 0); send(8'h61, 1, 0); send(8'h62, 0, 0);
    rob_empty = 0; blk = 0;
    idle(3);
    rob_empty = 1;
    idle(6);

    cur_req = "R9";
    blk = 1;
    send(8'h70, 0, 0); send(8'h71, 0, 0);
    squash = 1; idle(2);
    squash = 0; blk = 0;
    cur_req = "R10";
    in_valid = 1; in_tag = 8'h72;
    stream(2);
    in_valid = 0; idle(2);

    cur_req = "R9";
    rob_empty = 0;
    send(8'h80, 1, 0);
    idle(1);
    squash = 1; idle(1); squash = 0;
    rob_empty = 1;
    idle(3);
    in_valid = 1; in_tag = 8'h90; squash = 1;
    tick();
    squash = 0; in_valid = 0;
    cur_req = "R10";
    idle(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule